// File: doc/BRIEF.md
# Register-Programmed MDIO Management Master

This block lets software reach the management registers of an external Ethernet PHY through a small bank of 32-bit registers. Software writes the PHY address, the register number and, for a write, a 16-bit data word. It then writes the command register with the start bit set. The block sends one management frame on the serial clock and data pins, and raises a busy flag until the last bit has left the pin.

For a read, the block releases the data pin during the reply. It samples the 16 returned bits on rising clock edges and places them in the read-data register when busy drops. Software should poll busy to zero before it issues the next command. A start that arrives while busy is set is dropped, so the frame already on the wire is not disturbed.

The management clock is the system clock divided by the even parameter `CLK_DIV`. It stays low while the bus is idle. Outgoing bits change on falling edges and incoming bits are sampled on rising edges. A mode bit that selects the frame clause is stored for software, but every frame uses the 32-bit-preamble, 2-bit-opcode format described below.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy reads 0, `mdc` is low, `mdioOe` is low, the read-data register (offset 0x4C) reads 0 and the mode register (offset 0x40) reads 0x0000_0100.
- R2: The address register (0x44) keeps only the PHY address in bits [12:8] and the register number in bits [4:0]; the write-data register (0x48) keeps bits [15:0]; the mode register keeps only bit 8; all other bits read 0.
- R3: A write to the command register (0x50) with bit 8 set starts a frame, and bit 16 of the command register then reads 1 until the frame ends. Bit 0 of that write selects the operation (0 read, 1 write) and reads back as written. A write to the command register with bit 8 clear starts nothing.
- R4: A frame lasts exactly 64 `mdc` periods of `CLK_DIV` system clocks each, for 64×`CLK_DIV` cycles of busy in total. Outside a frame `mdc` does not toggle.
- R5: Every frame begins with 32 ones and then the bits 0,1. A write frame continues with opcode 0,1, the 5-bit PHY address, the 5-bit register number, turnaround 1,0 and the 16 data bits. All fields are sent MSB first and are valid at rising `mdc` edges.
- R6: A read frame carries opcode 1,0 and drives the first turnaround bit high. `mdioOe` drops at the start of the second turnaround bit (bit 47 of 64) and stays low to the end of the frame. A write frame keeps `mdioOe` high for all 64 bits.
- R7: During a read, the 16 bits sampled on the last 16 rising `mdc` edges (first bit = MSB) appear at 0x4C when busy clears. The register holds that value through later write frames until the next read completes.
- R8: A start request, or a write to the address or write-data register, that arrives while busy is set leaves the frame in progress unchanged in content and length.
- R9: While no frame is in progress, `mdioOe` is low.
- R10: Setting the mode bit (bit 8 of 0x40) does not change the frame that is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte offset of the register being written or read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven by the master |
| mdioOe | output | 1 | Output enable for `mdioOut` (1 = master drives the pin) |
| mdioIn | input | 1 | Management data returned from the pin |

## Verification
The bench sets `CLK_DIV` to 4, so each bit takes 4 system clocks and a whole frame takes 256 cycles. This keeps a full 64-bit frame, the exact busy length and several back-to-back transactions well inside the run budget. A behavioural PHY model in the bench captures every bit and every enable level on rising `mdc` edges. It also returns read data on falling edges, so field order, turnaround release and MSB-first capture are all compared bit by bit. `ADDR_W` stays at 8, which covers the full register offset range 0x40 to 0x50.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_RELEASE_IDX = 47;

  localparam int OFF_MODE = 'h40;
  localparam int OFF_ADDR = 'h44;
  localparam int OFF_WDAT = 'h48;
  localparam int OFF_RDAT = 'h4C;
  localparam int OFF_CMD  = 'h50;

  localparam int CMD_START_BIT = 8;
  localparam int CMD_BUSY_BIT  = 16;
  localparam int MODE_BIT      = 8;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic done;
  } mdioStrobe_t;

  function automatic logic [FRAME_BITS-1:0] buildFrame(
    input logic       isRead,
    input logic [4:0] phyAddr,
    input logic [4:0] regNum,
    input logic [15:0] data
  );
    logic [1:0]  opBits;
    logic [15:0] dataBits;
    opBits   = isRead ? 2'b10 : 2'b01;
    dataBits = isRead ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, opBits, phyAddr, regNum, 2'b10, dataBits};
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_master_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        opRead,
  output mdioStrobe_t strobe,
  output logic        busy,
  output logic        mdc,
  output logic        mdioOe
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(HALF + 1);
  localparam int IDX_W = $clog2(FRAME_BITS);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             halfEnd;
  logic             lastBit;
  logic             running;

  assign running = (state == ST_RUN);
  assign halfEnd = (divCnt == DIV_W'(HALF - 1));
  assign lastBit = (bitIdx == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    strobe.load   = !running && startReq;
    strobe.sample = running && halfEnd && !mdc;
    strobe.shift  = running && halfEnd && mdc && !lastBit;
    strobe.done   = running && halfEnd && mdc && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdc    <= 1'b0;
    end else if (strobe.load) begin
      state  <= ST_RUN;
      divCnt <= '0;
      bitIdx <= '0;
      mdc    <= 1'b0;
    end else if (running) begin
      if (halfEnd) begin
        divCnt <= '0;
        mdc    <= !mdc;
        if (mdc) begin
          if (lastBit) state <= ST_IDLE;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign busy   = running;
  assign mdioOe = running && !(opRead && (bitIdx >= IDX_W'(TA_RELEASE_IDX)));

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_master_pkg::*;
#(
  parameter int   ADDR_W   = 8,
  parameter logic MODE_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  mdioStrobe_t       strobe,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              startReq,
  output logic              opRead,
  output logic [15:0]       rdDataQ
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(OFF_ADDR);
  localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(OFF_WDAT);
  localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(OFF_RDAT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);

  logic                  modeQ;
  logic [4:0]            phyAddrQ;
  logic [4:0]            regNumQ;
  logic [15:0]           wrDataQ;
  logic                  opReadQ;
  logic [FRAME_BITS-1:0] frameQ;
  logic [15:0]           capQ;

  assign startReq = regWrEn && (regAddr == A_CMD) && regWrData[CMD_START_BIT];
  assign opRead   = opReadQ;
  assign mdioOut  = frameQ[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_RST;
      phyAddrQ <= '0;
      regNumQ  <= '0;
      wrDataQ  <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_MODE) modeQ <= regWrData[MODE_BIT];
      if (regAddr == A_ADDR) begin
        phyAddrQ <= regWrData[12:8];
        regNumQ  <= regWrData[4:0];
      end
      if (regAddr == A_WDAT) wrDataQ <= regWrData[15:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReadQ <= 1'b1;
      frameQ  <= '0;
    end else if (strobe.load) begin
      opReadQ <= !regWrData[0];
      frameQ  <= buildFrame(!regWrData[0], phyAddrQ, regNumQ, wrDataQ);
    end else if (strobe.shift) begin
      frameQ  <= {frameQ[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ    <= '0;
      rdDataQ <= '0;
    end else begin
      if (strobe.sample) capQ <= {capQ[14:0], mdioIn};
      if (strobe.done && opReadQ) rdDataQ <= capQ;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_MODE: regRdData[MODE_BIT] = modeQ;
      A_ADDR: regRdData = {19'd0, phyAddrQ, 3'd0, regNumQ};
      A_WDAT: regRdData = {16'd0, wrDataQ};
      A_RDAT: regRdData = {16'd0, rdDataQ};
      A_CMD: begin
        regRdData[CMD_BUSY_BIT] = busy;
        regRdData[0]            = !opReadQ;
      end
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int   ADDR_W   = 8,
  parameter int   CLK_DIV  = 8,
  parameter logic MODE_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  mdioStrobe_t strobe;
  logic        busy;
  logic        startReq;
  logic        opRead;
  logic [15:0] rdDataQ;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .opRead   (opRead),
    .strobe   (strobe),
    .busy     (busy),
    .mdc      (mdc),
    .mdioOe   (mdioOe)
  );

  mdio_datapath #(.ADDR_W(ADDR_W), .MODE_RST(MODE_RST)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busy      (busy),
    .strobe    (strobe),
    .mdioIn    (mdioIn),
    .mdioOut   (mdioOut),
    .startReq  (startReq),
    .opRead    (opRead),
    .rdDataQ   (rdDataQ)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              busy,
  input logic              mdc,
  input logic              mdioOe,
  input logic [15:0]       rdDataQ
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);

  // R9: pin released and clock parked low when no frame runs
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc));

  // R3: an accepted start raises busy on the next cycle
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && regWrEn && (regAddr == A_CMD) && regWrData[CMD_START_BIT]) |=> busy);

  // R4: the management clock moves only around a frame
  a_r4_mdc_only_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdc) |-> (busy || $past(busy)));

  // R6: once released inside a frame, the pin is not driven again
  a_r6_no_redrive: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !$rose(mdioOe));

  // R7: read data changes only when a frame ends
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busy) |-> $stable(rdDataQ));

endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .busy      (busy),
  .mdc       (mdc),
  .mdioOe    (mdioOe),
  .rdDataQ   (rdDataQ)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int ADDR_W  = 8;
  localparam int CLK_DIV = 4;
  localparam int FRAME_CYC = 64 * CLK_DIV;

  localparam logic [7:0] A_MODE = 8'h40;
  localparam logic [7:0] A_ADDR = 8'h44;
  localparam logic [7:0] A_WDAT = 8'h48;
  localparam logic [7:0] A_RDAT = 8'h4C;
  localparam logic [7:0] A_CMD  = 8'h50;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              mdc;
  logic              mdioOut;
  logic              mdioOe;
  logic              mdioIn = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  int          edgeCnt = 0;
  logic [63:0] capBits = '0;
  logic [63:0] capOe   = '0;
  logic [15:0] respWord = '0;

  mdio_master #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) i_mdio_master (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .mdc       (mdc),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .mdioIn    (mdioIn)
  );

  always #4 clk = !clk;

  // PHY model: capture on rising mdc, answer reads on falling mdc
  always @(posedge mdc) begin
    if (edgeCnt < 64) begin
      capBits[63 - edgeCnt] = mdioOut;
      capOe[63 - edgeCnt]   = mdioOe;
    end
    edgeCnt = edgeCnt + 1;
  end

  always @(negedge mdc) begin
    if (edgeCnt >= 48 && edgeCnt <= 63) mdioIn = respWord[63 - edgeCnt];
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // Starts a command and waits for busy to drop; returns observed busy cycles
  task automatic runCmd(input logic [31:0] cmd, output int busyCyc);
    edgeCnt = 0; capBits = '0; capOe = '0;
    regWrite(A_CMD, cmd);
    regAddr = A_CMD;
    #1;
    busyCyc = 0;
    while (regRdData[16] && busyCyc < 5000) begin
      busyCyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1", "mdc", {63'd0, mdc}, 64'd0);
    check("R1", "oe", {63'd0, mdioOe}, 64'd0);
    regRead(A_MODE, d); check("R1", "mode", {32'd0, d}, 64'h100);
    regRead(A_CMD, d);  check("R1", "cmd/busy", {32'd0, d}, 64'h0);
    regRead(A_RDAT, d); check("R1", "rddata", {32'd0, d}, 64'h0);
  endtask

  task automatic testMasks();
    logic [31:0] d;
    regWrite(A_ADDR, 32'hFFFF_FFFF); regRead(A_ADDR, d);
    check("R2", "addr mask", {32'd0, d}, 64'h1F1F);
    regWrite(A_WDAT, 32'hFFFF_FFFF); regRead(A_WDAT, d);
    check("R2", "wdata mask", {32'd0, d}, 64'hFFFF);
    regWrite(A_MODE, 32'hFFFF_FFFF); regRead(A_MODE, d);
    check("R2", "mode mask", {32'd0, d}, 64'h100);
    regWrite(A_MODE, 32'h0); regRead(A_MODE, d);
    check("R2", "mode clear", {32'd0, d}, 64'h0);
  endtask

  task automatic testWrite(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] val, input string req);
    logic [31:0] d;
    int cyc;
    regWrite(A_ADDR, {19'd0, phy, 3'd0, rg});
    regWrite(A_WDAT, {16'hDEAD, val});
    runCmd(32'h101, cyc);
    check("R4", "busy cycles", 64'(cyc), 64'(FRAME_CYC));
    check("R4", "mdc periods", 64'(edgeCnt), 64'd64);
    check(req, "write frame bits", capBits, expFrame(1'b0, phy, rg, val));
    check("R6", "write oe", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    regRead(A_CMD, d);
    check("R3", "cmd readback", {32'd0, d}, 64'h1);
  endtask

  task automatic testRead(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] resp);
    logic [31:0] d;
    int cyc;
    respWord = resp;
    regWrite(A_ADDR, {19'd0, phy, 3'd0, rg});
    runCmd(32'h100, cyc);
    check("R4", "read busy cycles", 64'(cyc), 64'(FRAME_CYC));
    check("R6", "read header bits", {capBits[63:17], 17'd0},
          {expFrame(1'b1, phy, rg, 16'h0) & 64'hFFFF_FFFF_FFFE_0000});
    check("R6", "read oe", capOe, 64'hFFFF_FFFF_FFFE_0000);
    regRead(A_RDAT, d);
    check("R7", "read data", {32'd0, d}, {48'd0, resp});
    regRead(A_CMD, d);
    check("R3", "read cmd readback", {32'd0, d}, 64'h0);
  endtask

  task automatic testStartWhileBusy();
    logic [31:0] d;
    logic [63:0] exp;
    exp = expFrame(1'b0, 5'h0A, 5'h15, 16'h1234);
    regWrite(A_ADDR, {19'd0, 5'h0A, 3'd0, 5'h15});
    regWrite(A_WDAT, 32'h1234);
    edgeCnt = 0; capBits = '0; capOe = '0;
    regWrite(A_CMD, 32'h101);
    repeat (40) @(negedge clk);
    regWrite(A_ADDR, {19'd0, 5'h11, 3'd0, 5'h02});
    regWrite(A_WDAT, 32'hFFFF);
    regWrite(A_CMD, 32'h100);
    repeat (20) @(negedge clk);
    regWrite(A_CMD, 32'h101);
    repeat (FRAME_CYC) @(negedge clk);
    check("R8", "frame bits kept", capBits, exp);
    check("R8", "frame length kept", 64'(edgeCnt), 64'd64);
    check("R8", "oe kept", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    regRead(A_CMD, d);
    check("R8", "idle afterwards", {32'd0, d}, 64'h1);
  endtask

  task automatic testNoStart();
    logic [31:0] d;
    edgeCnt = 0;
    regWrite(A_CMD, 32'h1);
    regRead(A_CMD, d);
    check("R3", "no busy without start bit", {32'd0, d[16]}, 64'd0);
    repeat (20) @(negedge clk);
    check("R3", "no mdc edges without start bit", 64'(edgeCnt), 64'd0);
    check("R9", "oe idle", {63'd0, mdioOe}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testMasks();
    testWrite(5'h05, 5'h1A, 16'hA5C3, "R5");
    begin
      logic [31:0] d;
      regRead(A_RDAT, d);
      check("R7", "rddata untouched by write", {32'd0, d}, 64'h0);
    end
    testRead(5'h1F, 5'h00, 16'h3C96);
    testRead(5'h00, 5'h1F, 16'h8001);
    testWrite(5'h13, 5'h07, 16'h0FF0, "R5");
    begin
      logic [31:0] d;
      regRead(A_RDAT, d);
      check("R7", "rddata held over write", {32'd0, d}, 64'h8001);
    end
    testStartWhileBusy();
    testNoStart();
    regWrite(A_MODE, 32'h100);
    testWrite(5'h1C, 5'h11, 16'h5A5A, "R10");
    check("R9", "oe after frame", {63'd0, mdioOe}, 64'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule